// File: doc/BRIEF.md
# Motor Current Acquisition Sequencer

This block runs the control side of a motor-current measurement front end. A host writes a control word that picks which motor phases (U, V, W) and which one of four auxiliary inputs are sampled in each acquisition pass. On a start strobe the block steps an external converter through the chosen channels through a request/done handshake. It stores each conversion in a result register of its own, which the host can read back.

When a pass finishes, the block raises a conversion-complete event. A separate rotation unit reports its own completion event on an input pin. Each event can be enabled on its own. The two are merged onto one active-low interrupt pin, which runs either as a one-tick pulse or as a level that the host clears by reading the status register. A control bit halves the rate of the internal system tick, for fast input clocks. The sequencing and the interrupt logic advance only on that tick.

Top module: `motor_adc_seq`

## Requirements
- R1: After reset the control word and the status flags read 0, `irq_n` is 1, `adc_req` is 0 and `sys_ce` is 1.
- R2: Phases V and W are always converted. Control bit 3 adds phase U and bit 4 adds the auxiliary channel. Within a pass the order is U, V, W, AUX, and unselected channels are skipped. `adc_chan` carries U=0, V=1, W=2 and AUX=4+n. The selection is captured at start, so control writes made during a pass do not change that pass.
- R3: Control bits 1:0 pick the auxiliary input n (0..3), so the AUX channel is presented as code 4+n.
- R4: Each accepted conversion is stored per channel and is readable at bus address 2 (U), 3 (V), 4 (W) and 5 (AUX), zero-extended.
- R5: A start strobe that arrives while a pass is running is ignored, and that pass converts each selected channel exactly once.
- R6: Control bit 7 enables the interrupt for pass completion and bit 6 enables it for rotation completion. A disabled event leaves `irq_n` high but still sets its status flag.
- R7: With control bit 8 at 0, each enabled event drives `irq_n` low for exactly one system tick: one clock at full rate, or two clocks at half rate.
- R8: With control bit 8 at 1, an enabled event drives `irq_n` low, and it stays low until the status register (address 1) is read.
- R9: Status bit 0 (pass complete) and bit 1 (rotation complete) are sticky. A read returns them and then clears them. An event in the same clock as the read leaves its flag set.
- R10: With control bit 5 set, `sys_ce` is high on every second clock, and the sequencer and interrupt logic advance only on those clocks.
- R11: Control address 0 stores only bits 0,1,3,4,5,6,7,8,10, which read back as written (mask 0x05FB). Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (a status read clears the flags) |
| bus_addr | input | ADDR_W | Host register address |
| bus_wdata | input | BUS_W | Host write data |
| bus_rdata | output | BUS_W | Host read data for the current address |
| acq_start | input | 1 | Start strobe for an acquisition pass |
| rot_done | input | 1 | Completion event from the rotation unit |
| adc_req | output | 1 | Conversion request, held while a pass runs |
| adc_chan | output | 3 | Channel code of the current request |
| adc_done | input | 1 | Converter result-valid strobe |
| adc_data | input | DATA_W | Converter result |
| sys_ce | output | 1 | System tick enable |
| irq_n | output | 1 | Merged active-low interrupt |

## Verification
The hardest case to reach is a status read that lands in the same clock as an event that sets a flag. It needs a read strobe and a rotation-done strobe driven on the same tick. The bench arranges this in level mode, then checks that the read returned the old flag, that the pin stays low, and that a second read returns the new flag. A second hard case is half-rate operation. There, every strobe must fall on a tick where `sys_ce` is high, so the bench's converter model and its strobe tasks wait for such a clock. A cycle-level reference model then follows the sequencing and the two-clock interrupt pulse.

// File: rtl/msq_pkg.sv
package msq_pkg;
   // control word bit positions (decoded by the block)
   localparam int CB_AUX_LO  = 0;
   localparam int CB_PH_U    = 3;
   localparam int CB_AUX_EN  = 4;
   localparam int CB_HALF    = 5;
   localparam int CB_IE_ROT  = 6;
   localparam int CB_IE_CONV = 7;
   localparam int CB_LVL     = 8;
   localparam int CB_DIR     = 10;

   localparam int NSLOT  = 4;
   localparam int SLOT_W = $clog2(NSLOT);
   localparam int CHAN_W = 3;

   localparam int ADR_CTRL = 0;
   localparam int ADR_STAT = 1;
   localparam int ADR_RES0 = 2;

   localparam int NFLAG    = 2;
   localparam int FL_CONV  = 0;
   localparam int FL_ROT   = 1;

   typedef enum logic {SQ_IDLE = 1'b0, SQ_CONV = 1'b1} sq_state_t;

   typedef struct packed {
      logic       lvl_mode;
      logic       ie_conv;
      logic       ie_rot;
      logic       half;
      logic       aux_en;
      logic       ph_u;
      logic [1:0] aux_idx;
   } ctrl_t;
endpackage

// File: rtl/msq_regs.sv
module msq_regs
   import msq_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [BUS_W-1:0]        bus_wdata,
   output logic [BUS_W-1:0]        bus_rdata,
   output ctrl_t                   ctrl,
   input  logic                    conv_evt,
   input  logic                    rot_evt,
   input  logic [NSLOT*DATA_W-1:0] res_flat,
   output logic                    stat_rd,
   output logic [NFLAG-1:0]        stat_q
);
   localparam logic [BUS_W-1:0] WR_MASK = BUS_W'((1 << CB_DIR) | (1 << CB_LVL) |
      (1 << CB_IE_CONV) | (1 << CB_IE_ROT) | (1 << CB_HALF) | (1 << CB_AUX_EN) |
      (1 << CB_PH_U) | (3 << CB_AUX_LO));

   logic [BUS_W-1:0] ctrl_raw;
   logic             wr_ctrl;
   logic [NFLAG-1:0] flag_set;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
   assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_raw <= '0;
      else if (wr_ctrl) ctrl_raw <= bus_wdata & WR_MASK;
   end

   always_comb begin
      ctrl.aux_idx  = ctrl_raw[CB_AUX_LO +: 2];
      ctrl.ph_u     = ctrl_raw[CB_PH_U];
      ctrl.aux_en   = ctrl_raw[CB_AUX_EN];
      ctrl.half     = ctrl_raw[CB_HALF];
      ctrl.ie_rot   = ctrl_raw[CB_IE_ROT];
      ctrl.ie_conv  = ctrl_raw[CB_IE_CONV];
      ctrl.lvl_mode = ctrl_raw[CB_LVL];
   end

   assign flag_set[FL_CONV] = conv_evt;
   assign flag_set[FL_ROT]  = rot_evt;

   // sticky flags: a set in the read cycle wins over the clear
   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           stat_q[f] <= 1'b0;
         else if (flag_set[f]) stat_q[f] <= 1'b1;
         else if (stat_rd)     stat_q[f] <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_CTRL)) bus_rdata = ctrl_raw;
      if (bus_addr == ADDR_W'(ADR_STAT)) bus_rdata = BUS_W'(stat_q);
      for (int s = 0; s < NSLOT; s++) begin
         if (bus_addr == ADDR_W'(ADR_RES0 + s))
            bus_rdata = BUS_W'(res_flat[s*DATA_W +: DATA_W]);
      end
   end
endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
   import msq_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce,
   input  logic                    go,
   input  logic                    sel_u,
   input  logic                    sel_aux,
   input  logic [1:0]              aux_idx,
   input  logic                    adc_done,
   input  logic [DATA_W-1:0]       adc_data,
   output logic                    adc_req,
   output logic [CHAN_W-1:0]       adc_chan,
   output logic                    conv_evt,
   output logic [NSLOT*DATA_W-1:0] res_flat
);
   localparam logic [SLOT_W-1:0] SLOT_AUX = SLOT_W'(NSLOT - 1);

   sq_state_t         state_q;
   logic [NSLOT-1:0]  mask_q;
   logic [NSLOT-1:0]  start_mask;
   logic [SLOT_W-1:0] cur_q;
   logic [SLOT_W-1:0] first_slot;
   logic [SLOT_W-1:0] nxt_slot;
   logic              nxt_valid;
   logic [1:0]        aux_q;
   logic              accept;

   always_comb begin
      start_mask    = '1;
      start_mask[0] = sel_u;
      start_mask[NSLOT-1] = sel_aux;
      first_slot = '0;
      for (int j = NSLOT - 1; j >= 0; j--)
         if (start_mask[j]) first_slot = SLOT_W'(j);
      nxt_valid = 1'b0;
      nxt_slot  = '0;
      for (int j = NSLOT - 1; j >= 0; j--) begin
         if (mask_q[j] && (j > int'(cur_q))) begin
            nxt_valid = 1'b1;
            nxt_slot  = SLOT_W'(j);
         end
      end
   end

   assign accept   = ce && (state_q == SQ_CONV) && adc_done;
   assign conv_evt = accept && !nxt_valid;
   assign adc_req  = (state_q == SQ_CONV);
   assign adc_chan = (cur_q == SLOT_AUX) ? {1'b1, aux_q} : {1'b0, cur_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mask_q  <= '0;
         cur_q   <= '0;
         aux_q   <= '0;
      end else if (ce) begin
         case (state_q)
            SQ_IDLE: if (go) begin
               state_q <= SQ_CONV;
               mask_q  <= start_mask;
               cur_q   <= first_slot;
               aux_q   <= aux_idx;
            end
            SQ_CONV: if (adc_done) begin
               if (nxt_valid) cur_q   <= nxt_slot;
               else           state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_res
      logic [DATA_W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  res_q <= '0;
         else if (accept && (cur_q == SLOT_W'(g)))    res_q <= adc_data;
      end
      assign res_flat[g*DATA_W +: DATA_W] = res_q;
   end
endmodule

// File: rtl/msq_irq.sv
module msq_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ce,
   input  logic lvl_mode,
   input  logic fire,
   input  logic stat_rd,
   output logic irq_n
);
   logic pulse_q;
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pulse_q <= 1'b0;
      else if (ce) pulse_q <= fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q <= 1'b0;
      else if (fire)    lvl_q <= 1'b1;
      else if (stat_rd) lvl_q <= 1'b0;
   end

   assign irq_n = !(lvl_mode ? lvl_q : pulse_q);
endmodule

// File: rtl/motor_adc_seq.sv
module motor_adc_seq
   import msq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int BUS_W        = 16,
   parameter int ADDR_W       = 3,
   parameter bit HALF_RATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              acq_start,
   input  logic              rot_done,
   output logic              adc_req,
   output logic [2:0]        adc_chan,
   input  logic              adc_done,
   input  logic [DATA_W-1:0] adc_data,
   output logic              sys_ce,
   output logic              irq_n
);
   if (DATA_W > BUS_W) begin : g_bad_data_w
      $error("DATA_W must not exceed BUS_W");
   end
   if (BUS_W <= CB_DIR) begin : g_bad_bus_w
      $error("BUS_W too narrow for the control word");
   end
   if ((1 << ADDR_W) < ADR_RES0 + NSLOT) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   ctrl_t                   ctrl;
   logic                    conv_evt;
   logic                    rot_evt;
   logic                    fire;
   logic                    stat_rd;
   logic [NFLAG-1:0]        stat_q;
   logic [NSLOT*DATA_W-1:0] res_flat;

   if (HALF_RATE_EN) begin : g_half
      logic tog_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tog_q <= 1'b0;
         else        tog_q <= !tog_q;
      end
      assign sys_ce = ctrl.half ? tog_q : 1'b1;
   end else begin : g_full
      assign sys_ce = 1'b1;
   end

   assign rot_evt = rot_done && sys_ce;
   assign fire    = (conv_evt && ctrl.ie_conv) || (rot_evt && ctrl.ie_rot);

   msq_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ctrl(ctrl), .conv_evt(conv_evt), .rot_evt(rot_evt),
      .res_flat(res_flat), .stat_rd(stat_rd), .stat_q(stat_q)
   );

   msq_sequencer #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ce(sys_ce), .go(acq_start),
      .sel_u(ctrl.ph_u), .sel_aux(ctrl.aux_en), .aux_idx(ctrl.aux_idx),
      .adc_done(adc_done), .adc_data(adc_data), .adc_req(adc_req),
      .adc_chan(adc_chan), .conv_evt(conv_evt), .res_flat(res_flat)
   );

   msq_irq u_irq (
      .clk(clk), .rst_n(rst_n), .ce(sys_ce), .lvl_mode(ctrl.lvl_mode),
      .fire(fire), .stat_rd(stat_rd), .irq_n(irq_n)
   );
endmodule

// File: rtl/msq_checker.sv
module msq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       lvl_mode,
   input logic       half,
   input logic       sys_ce,
   input logic       acq_start,
   input logic       adc_req,
   input logic       adc_done,
   input logic [2:0] adc_chan,
   input logic       conv_evt,
   input logic       rot_evt,
   input logic       fire,
   input logic       stat_rd,
   input logic [1:0] stat_q,
   input logic       irq_n
);
   AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |-> (adc_chan != 3'd3)); // R2

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_req && acq_start && !adc_done) |=> (adc_req && $stable(adc_chan))); // R5

   AST_PULSE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && !half && !irq_n && !fire) |=> (irq_n || lvl_mode)); // R7

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mode && !irq_n && !stat_rd) |=> (!irq_n || !lvl_mode)); // R8

   AST_CONV_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && conv_evt) |=> stat_q[0]); // R9

   AST_ROT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && rot_evt) |=> stat_q[1]); // R9

   AST_HALF_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (half && $past(half)) |-> (sys_ce != $past(sys_ce))); // R10
endmodule

bind motor_adc_seq msq_checker u_chk (
   .clk(clk), .rst_n(rst_n), .lvl_mode(ctrl.lvl_mode), .half(ctrl.half),
   .sys_ce(sys_ce), .acq_start(acq_start), .adc_req(adc_req),
   .adc_done(adc_done), .adc_chan(adc_chan), .conv_evt(conv_evt),
   .rot_evt(rot_evt), .fire(fire), .stat_rd(stat_rd), .stat_q(stat_q),
   .irq_n(irq_n)
);

// File: tb/sim_motor_adc_seq.sv
module sim_motor_adc_seq;
   localparam int DW = 12;
   localparam int BW = 16;
   localparam int AW = 3;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [BW-1:0] bus_wdata = '0;
   logic [BW-1:0] bus_rdata;
   logic          acq_start = 1'b0, rot_done = 1'b0;
   logic          adc_req, adc_done = 1'b0;
   logic [2:0]    adc_chan;
   logic [DW-1:0] adc_data = '0;
   logic          sys_ce, irq_n;

   int tests = 0, fails = 0;

   always #5 clk = ~clk;

   motor_adc_seq u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .acq_start(acq_start), .rot_done(rot_done), .adc_req(adc_req),
      .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data),
      .sys_ce(sys_ce), .irq_n(irq_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   bit [15:0] m_ctrl;
   bit        m_tog, m_busy, m_pulse, m_lvl;
   bit [1:0]  m_st;
   int        m_q[$];
   int        m_res[4];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_tog = 0; m_busy = 0; m_pulse = 0; m_lvl = 0; m_st = 0;
         m_q.delete();
         foreach (m_res[i]) m_res[i] = 0;
      end else begin
         bit ce, conv, rot, fire, srd;
         ce = m_ctrl[5] ? m_tog : 1'b1;
         conv = 0;
         if (ce) begin
            if (!m_busy && acq_start) begin
               if (m_ctrl[3]) m_q.push_back(0);
               m_q.push_back(1);
               m_q.push_back(2);
               if (m_ctrl[4]) m_q.push_back(4 + int'(m_ctrl[1:0]));
               m_busy = 1;
            end else if (m_busy && adc_done) begin
               m_res[(m_q[0] < 4) ? m_q[0] : 3] = int'(adc_data);
               void'(m_q.pop_front());
               if (m_q.size() == 0) begin m_busy = 0; conv = 1; end
            end
         end
         rot  = ce && rot_done;
         fire = (conv && m_ctrl[7]) || (rot && m_ctrl[6]);
         srd  = bus_rd && (bus_addr == 3'd1);
         if (ce) m_pulse = fire;
         if (fire) m_lvl = 1; else if (srd) m_lvl = 0;
         if (conv) m_st[0] = 1; else if (srd) m_st[0] = 0;
         if (rot)  m_st[1] = 1; else if (srd) m_st[1] = 0;
         if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata & 16'h05FB;
         m_tog = !m_tog;
      end
   end

   function automatic int model_read(input int a);
      case (a)
         0: return int'(m_ctrl);
         1: return int'(m_st);
         2, 3, 4, 5: return m_res[a-2];
         default: return 0;
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_irq, e_ce;
         e_irq = !(m_ctrl[8] ? m_lvl : m_pulse);
         e_ce  = m_ctrl[5] ? m_tog : 1'b1;
         chk(irq_n == e_irq, "R7/R8", "irq_n", irq_n, e_irq);
         chk(sys_ce == e_ce, "R10", "sys_ce", sys_ce, e_ce);
         chk(adc_req == m_busy, "R5", "adc_req", adc_req, m_busy);
         if (m_busy) chk(int'(adc_chan) == m_q[0], "R2", "adc_chan", adc_chan, m_q[0]);
      end
   end

   // ---------------- converter stand-in ----------------
   int cnt = 0, ser = 0;
   int chan_log[$];
   int low_cnt = 0;

   always @(negedge clk) begin
      if (adc_done) adc_done = 1'b0;
      else if (adc_req) begin
         if (cnt >= LAT && sys_ce) begin
            ser++;
            adc_done = 1'b1;
            adc_data = DW'((int'(adc_chan) << 8) | (ser & 255));
            chan_log.push_back(int'(adc_chan));
            cnt = 0;
         end else cnt++;
      end else cnt = 0;
      if (rst_n && !irq_n) low_cnt++;
   end

   // ---------------- host and strobe tasks ----------------
   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1; bus_addr = AW'(a); bus_wdata = BW'(d);
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd_chk(input int a, input string req);
      int e;
      @(negedge clk);
      bus_rd = 1; bus_addr = AW'(a);
      #1;
      e = model_read(a);
      chk(int'(bus_rdata) == e, req, $sformatf("read addr %0d", a), bus_rdata, e);
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic tick_strobe(input bit is_rot);
      @(negedge clk);
      while (!sys_ce) @(negedge clk);
      if (is_rot) rot_done = 1; else acq_start = 1;
      @(negedge clk);
      rot_done = 0; acq_start = 0;
   endtask

   task automatic run_cycle();
      chan_log.delete();
      low_cnt = 0;
      tick_strobe(0);
      while (adc_req) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_order(input int set_u, input int set_aux, input int aux, input string req);
      int exp[$];
      if (set_u) exp.push_back(0);
      exp.push_back(1);
      exp.push_back(2);
      if (set_aux) exp.push_back(4 + aux);
      chk(chan_log.size() == exp.size(), req, "channel count", chan_log.size(), exp.size());
      for (int k = 0; k < exp.size() && k < chan_log.size(); k++)
         chk(chan_log[k] == exp[k], req, $sformatf("channel #%0d", k), chan_log[k], exp[k]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk(irq_n == 1'b1, "R1", "irq_n", irq_n, 1);
      chk(adc_req == 1'b0, "R1", "adc_req", adc_req, 0);
      chk(sys_ce == 1'b1, "R1", "sys_ce", sys_ce, 1);
      rd_chk(0, "R1");
      rd_chk(1, "R1");

      // R11 writable mask
      wr(0, 16'hFFFF);
      chk(model_read(0) == 16'h05FB, "R11", "model mask", model_read(0), 16'h05FB);
      rd_chk(0, "R11");
      wr(0, 16'h0000);

      // R2 / R3 / R4 / R7: every channel set and auxiliary input
      for (int s = 0; s < 4; s++) begin
         for (int a = 0; a < 4; a++) begin
            wr(0, a | (s << 3) | 16'h0080);
            run_cycle();
            chk_order(s & 1, (s >> 1) & 1, a, "R2 R3");
            chk(low_cnt == 1, "R7", "pulse clocks", low_cnt, 1);
            for (int r = 2; r < 6; r++) rd_chk(r, "R4");
            rd_chk(1, "R9");
         end
      end

      // R2 selection captured at start
      wr(0, 16'h0018);
      chan_log.delete();
      tick_strobe(0);
      wr(0, 16'h0000);
      while (adc_req) @(negedge clk);
      chk_order(1, 1, 0, "R2");

      // R5 start during a pass
      wr(0, 16'h0098);
      chan_log.delete();
      tick_strobe(0);
      repeat (2) @(negedge clk);
      tick_strobe(0);
      while (adc_req) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(chan_log.size() == 4, "R5", "conversions", chan_log.size(), 4);
      chk(adc_req == 1'b0, "R5", "idle after pass", adc_req, 0);

      // R6 disabled events keep the pin high but set flags
      wr(0, 16'h0000);
      rd_chk(1, "R9");
      run_cycle();
      tick_strobe(1);
      repeat (3) @(negedge clk);
      chk(low_cnt == 0, "R6", "masked pulses", low_cnt, 0);
      chk(model_read(1) == 3, "R6", "model flags", model_read(1), 3);
      rd_chk(1, "R6");
      wr(0, 16'h0040);
      low_cnt = 0;
      tick_strobe(1);
      repeat (3) @(negedge clk);
      chk(low_cnt == 1, "R6", "rotation pulse", low_cnt, 1);

      // R8 level mode
      wr(0, 16'h0180);
      rd_chk(1, "R9");
      run_cycle();
      repeat (5) @(negedge clk);
      chk(irq_n == 1'b0, "R8", "held low", irq_n, 0);
      rd_chk(1, "R8");
      chk(irq_n == 1'b1, "R8", "released by read", irq_n, 1);

      // R9 event in the same clock as a status read
      wr(0, 16'h0140);
      rd_chk(1, "R9");
      @(negedge clk);
      while (!sys_ce) @(negedge clk);
      bus_rd = 1; bus_addr = 3'd1; rot_done = 1;
      #1;
      v = int'(bus_rdata);
      chk((v & 2) == 0, "R9", "flag before event", v, 0);
      @(negedge clk);
      bus_rd = 0; rot_done = 0;
      chk(irq_n == 1'b0, "R9", "pin low after collision", irq_n, 0);
      chk(model_read(1) == 2, "R9", "model flag kept", model_read(1), 2);
      rd_chk(1, "R9");
      @(negedge clk);
      chk(irq_n == 1'b1, "R9", "pin released", irq_n, 1);

      // R10 half-rate tick
      wr(0, 16'h00BA);
      @(negedge clk);
      v = sys_ce;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(sys_ce != v[0], "R10", "alternation", sys_ce, !v[0]);
         v = sys_ce;
      end
      run_cycle();
      chk_order(1, 1, 2, "R10");
      chk(low_cnt == 2, "R7 R10", "half-rate pulse clocks", low_cnt, 2);
      for (int r = 2; r < 6; r++) rd_chk(r, "R4");

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule